// File: doc/BRIEF.md
# Prioritised Board Status LED Controller

This block turns a handful of board status levels into the pattern shown on a board's status lights. It drives four single-colour lights and a configurable number of two-colour lights. Each two-colour light has a green pin and an orange pin. A priority resolver chooses one of three display modes, evaluated in this order:

- **Power fault.** Power-good is low.
- **Route override.** The JTAG-route switch is high.
- **Normal status.** Neither of the above applies.

A free-running prescaler divides the system clock down to a slow blink. Every light that blinks uses that one shared phase.

In normal status the lights show live board activity: the two UART lines, two user request inputs, and the boot-mode selection. The boot mode is formed from power-good and the boot-mode pin. The two-colour lights show green for a flash boot and orange for a card boot. All inputs are expected to be static or already synchronous to the clock. Every output is registered, so each light reflects its inputs and the blink phase one cycle later.

Top module: `board_led_ctrl`

## Requirements
- R1: While `pwr_good_i` is 0, the lights are in power-fault mode regardless of the mode pin:
  - `led_o[0]` and `led_o[1]` equal the blink phase.
  - `led_o[3:2]` are 0.
  - Every orange pin equals the blink phase.
  - Every green pin is 0.
- R2: While `pwr_good_i` is 1 and `route_sel_i` is 1, the lights are in route-override mode:
  - `led_o` is 4'b1111.
  - Every green pin equals the blink phase.
  - Every orange pin equals its inverse, so the colour changes on each phase edge with no dark step between colours.
- R3: In normal mode (`pwr_good_i`=1, `route_sel_i`=0), `led_o[0]` follows `uart_rx_i` and `led_o[1]` follows `uart_tx_i`.
- R4: In normal mode, `led_o[2]` follows `user_a_i` and `led_o[3]` follows `user_b_i`.
- R5: In normal mode, the two-colour lights depend on `boot_pin_i`:
  - When it is 1 (boot code 11, flash boot), every green pin is 1 and every orange pin is 0.
  - When it is 0 (boot code 10, card boot), every orange pin is 1 and every green pin is 0.
  - No two-colour light ever has both pins on in the same cycle.
- R6: The blink phase works as follows:
  - It is 0 after reset.
  - It inverts every `CLK_HZ/(2*BLINK_HZ)` clock cycles. That gives about 1 Hz with the defaults of 24.18 MHz and 1 Hz.
  - It is shared by every blinking pin.
- R7: Every output is registered. The value present after clock edge k is computed from the inputs and blink phase present before edge k.
- R8: While synchronous `rst` is high, all outputs are 0 one cycle later. The blink prescaler restarts from phase 0.
- R9: In power-fault mode, `route_sel_i`, `boot_pin_i`, the UART lines and the user inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_good_i | input | 1 | Power-good level, also the upper boot-mode bit |
| route_sel_i | input | 1 | JTAG-route switch level, high selects the override display |
| boot_pin_i | input | 1 | Boot-mode pin, the lower boot-mode bit |
| uart_rx_i | input | 1 | UART receive line |
| uart_tx_i | input | 1 | UART transmit line |
| user_a_i | input | 1 | User light request for light 3 |
| user_b_i | input | 1 | User light request for light 4 |
| led_o | output | 4 | Single-colour lights 1 to 4, active high |
| bicolor_grn_o | output | NUM_BICOLOR | Green pin of each two-colour light |
| bicolor_org_o | output | NUM_BICOLOR | Orange pin of each two-colour light |

## Verification
The hardest case to reach is a mode change that coincides with a blink-phase edge. It is also hard to confirm the phase right after a reset that lands mid-run, because the blink period is millions of cycles at the default clock.

The bench therefore shrinks the prescaler to a five-cycle half period. It changes the inputs at random on every cycle, so mode switches fall on every phase position. It also inserts directed holds in each mode that span several phase edges. Finally, it asserts reset in the middle of a half period and checks that the phase restarts from 0.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

  typedef enum logic [1:0] {
    DISP_FAULT  = 2'd0,
    DISP_ROUTE  = 2'd1,
    DISP_NORMAL = 2'd2
  } disp_mode_e;

  // Priority: power fault first, then route override, then normal status.
  function automatic disp_mode_e pick_mode(input logic pwr_good, input logic route_sel);
    if (!pwr_good)      return DISP_FAULT;
    else if (route_sel) return DISP_ROUTE;
    else                return DISP_NORMAL;
  endfunction

  // Half blink period in clock cycles, never below one.
  function automatic int unsigned half_period(input int unsigned clk_hz, input int unsigned blink_hz);
    int unsigned p;
    p = clk_hz / (2 * blink_hz);
    return (p == 0) ? 1 : p;
  endfunction

endpackage

// File: rtl/led_blink_div.sv
module led_blink_div #(
  parameter int unsigned TOGGLE_CYCLES = 12_090_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic phase_o
);
  localparam int unsigned CNT_W = (TOGGLE_CYCLES > 1) ? $clog2(TOGGLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOGGLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (tick_o) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_mode_resolver.sv
module led_mode_resolver
  import led_ctrl_pkg::*;
(
  input  logic       pwr_good_i,
  input  logic       route_sel_i,
  output disp_mode_e mode_o
);
  assign mode_o = pick_mode(pwr_good_i, route_sel_i);
endmodule

// File: rtl/led_frame_encoder.sv
module led_frame_encoder
  import led_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BICOLOR = 2
) (
  input  disp_mode_e             mode_i,
  input  logic                   phase_i,
  input  logic                   boot_pin_i,
  input  logic                   uart_rx_i,
  input  logic                   uart_tx_i,
  input  logic                   user_a_i,
  input  logic                   user_b_i,
  output logic [3:0]             mono_o,
  output logic [NUM_BICOLOR-1:0] grn_o,
  output logic [NUM_BICOLOR-1:0] org_o
);
  logic grn_one, org_one;

  always_comb begin
    unique case (mode_i)
      DISP_FAULT: begin
        mono_o  = {2'b00, phase_i, phase_i};
        grn_one = 1'b0;
        org_one = phase_i;
      end
      DISP_ROUTE: begin
        mono_o  = 4'b1111;
        grn_one = phase_i;
        org_one = ~phase_i;
      end
      default: begin
        mono_o  = {user_b_i, user_a_i, uart_tx_i, uart_rx_i};
        grn_one = boot_pin_i;
        org_one = ~boot_pin_i;
      end
    endcase
  end

  for (genvar g = 0; g < NUM_BICOLOR; g++) begin : g_bicolor
    assign grn_o[g] = grn_one;
    assign org_o[g] = org_one;
  end
endmodule

// File: rtl/board_led_ctrl.sv
module board_led_ctrl
  import led_ctrl_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 24_180_000,
  parameter int unsigned BLINK_HZ    = 1,
  parameter int unsigned NUM_BICOLOR = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwr_good_i,
  input  logic                   route_sel_i,
  input  logic                   boot_pin_i,
  input  logic                   uart_rx_i,
  input  logic                   uart_tx_i,
  input  logic                   user_a_i,
  input  logic                   user_b_i,
  output logic [3:0]             led_o,
  output logic [NUM_BICOLOR-1:0] bicolor_grn_o,
  output logic [NUM_BICOLOR-1:0] bicolor_org_o
);
  localparam int unsigned TOGGLE_CYCLES = half_period(CLK_HZ, BLINK_HZ);

  // Internal events, named for the checker.
  logic                   phase_tick;
  logic                   blink_phase;
  disp_mode_e             disp_mode;
  logic [3:0]             mono_d;
  logic [NUM_BICOLOR-1:0] grn_d, org_d;

  led_blink_div #(.TOGGLE_CYCLES(TOGGLE_CYCLES)) u_div (
    .clk     (clk),
    .rst     (rst),
    .tick_o  (phase_tick),
    .phase_o (blink_phase)
  );

  led_mode_resolver u_mode (
    .pwr_good_i  (pwr_good_i),
    .route_sel_i (route_sel_i),
    .mode_o      (disp_mode)
  );

  led_frame_encoder #(.NUM_BICOLOR(NUM_BICOLOR)) u_enc (
    .mode_i     (disp_mode),
    .phase_i    (blink_phase),
    .boot_pin_i (boot_pin_i),
    .uart_rx_i  (uart_rx_i),
    .uart_tx_i  (uart_tx_i),
    .user_a_i   (user_a_i),
    .user_b_i   (user_b_i),
    .mono_o     (mono_d),
    .grn_o      (grn_d),
    .org_o      (org_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_o         <= '0;
      bicolor_grn_o <= '0;
      bicolor_org_o <= '0;
    end else begin
      led_o         <= mono_d;
      bicolor_grn_o <= grn_d;
      bicolor_org_o <= org_d;
    end
  end
endmodule

// File: rtl/led_ctrl_checker.sv
module led_ctrl_checker #(
  parameter int unsigned NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          pwr_good_i,
  input logic          route_sel_i,
  input logic          boot_pin_i,
  input logic          uart_rx_i,
  input logic          user_a_i,
  input logic [3:0]    led_o,
  input logic [NB-1:0] grn,
  input logic [NB-1:0] org,
  input logic          phase_tick,
  input logic          blink_phase
);
  AST_FAULT_UPPER_DARK: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> (led_o[3:2] == 2'b00 && grn == '0)); // R1

  AST_FAULT_FOLLOWS_PHASE: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> (led_o[0] == $past(blink_phase) && org[0] == $past(blink_phase))); // R9

  AST_ROUTE_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && route_sel_i) |=> (led_o == 4'hF && (grn ^ org) == '1)); // R2

  AST_NORMAL_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && !route_sel_i) |=> (led_o[0] == $past(uart_rx_i) && led_o[2] == $past(user_a_i))); // R3

  AST_BOOT_COLOUR: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && !route_sel_i) |=> (grn[0] == $past(boot_pin_i))); // R5

  AST_NO_DUAL_COLOUR: assert property (@(posedge clk) disable iff (rst)
    (grn & org) == '0); // R5

  AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !phase_tick |=> $stable(blink_phase)); // R6

  AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    phase_tick |=> (blink_phase != $past(blink_phase))); // R6

  AST_RESET_DARK: assert property (@(posedge clk)
    $past(rst) |-> (led_o == 4'h0 && grn == '0 && org == '0)); // R8
endmodule

bind board_led_ctrl led_ctrl_checker #(.NB(NUM_BICOLOR)) u_led_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_good_i  (pwr_good_i),
  .route_sel_i (route_sel_i),
  .boot_pin_i  (boot_pin_i),
  .uart_rx_i   (uart_rx_i),
  .user_a_i    (user_a_i),
  .led_o       (led_o),
  .grn         (bicolor_grn_o),
  .org         (bicolor_org_o),
  .phase_tick  (phase_tick),
  .blink_phase (blink_phase)
);

// File: tb/test_board_led_ctrl.sv
module test_board_led_ctrl;
  localparam int unsigned T_HALF = 5;   // CLK_HZ=10, BLINK_HZ=1 gives a 5-cycle half period
  localparam int unsigned NBC    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg = 1'b0, route = 1'b0, boot = 1'b0, rx = 1'b0, tx = 1'b0, ua = 1'b0, ub = 1'b0;
  logic [3:0]     led;
  logic [NBC-1:0] grn, org;

  int checks = 0;
  int fails  = 0;
  int edge_cnt = 0;
  logic held_rst = 1'b1;
  logic done = 1'b0;

  board_led_ctrl #(.CLK_HZ(10), .BLINK_HZ(1), .NUM_BICOLOR(NBC)) i_board_led_ctrl (
    .clk(clk), .rst(rst), .pwr_good_i(pg), .route_sel_i(route), .boot_pin_i(boot),
    .uart_rx_i(rx), .uart_tx_i(tx), .user_a_i(ua), .user_b_i(ub),
    .led_o(led), .bicolor_grn_o(grn), .bicolor_org_o(org)
  );

  always #10 clk = ~clk;   // 50 MHz

  // Count clock edges since reset was released.
  always @(posedge clk) begin
    if (rst) edge_cnt <= 0;
    else     edge_cnt <= edge_cnt + 1;
  end

  // Expected phase before edge k is ((k-1)/T_HALF) mod 2 (R6).
  function automatic logic exp_phase(input int k);
    return ((k - 1) / T_HALF) % 2 == 1;
  endfunction

  // Expected {led[3:0], green, orange} for one input set and phase.
  function automatic logic [5:0] exp_frame(input logic p, r, b, rxv, txv, a, bb, ph);
    if (!p)     return {2'b00, ph, ph, 1'b0, ph};      // R1, R9
    else if (r) return {4'b1111, ph, ~ph};             // R2
    else        return {bb, a, txv, rxv, b, ~b};        // R3, R4, R5
  endfunction

  function automatic string tag_of(input logic p, r);
    if (!p)     return "R1/R9";
    else if (r) return "R2";
    else        return "R3/R4/R5";
  endfunction

  task automatic check_now();
    logic [5:0] e;
    logic [7:0] got, want;
    string tag;
    checks++;
    if (held_rst) begin
      want = '0;
      tag  = "R8";
    end else begin
      e    = exp_frame(pg, route, boot, rx, tx, ua, ub, exp_phase(edge_cnt));
      want = {e[5:2], {NBC{e[1]}}, {NBC{e[0]}}};
      tag  = {tag_of(pg, route), " R6 R7"};
    end
    got = {led, grn, org};
    if (got !== want) begin
      fails++;
      $display("FAIL %s edge=%0d actual=%b expected=%b", tag, edge_cnt, got, want);
    end
  endtask

  task automatic drive(input logic r_in, p, r, b, rxv, txv, a, bb);
    rst = r_in; held_rst = r_in;
    pg = p; route = r; boot = b; rx = rxv; tx = txv; ua = a; ub = bb;
  endtask

  // Check the previous cycle's result, then apply new inputs.
  task automatic step(input logic r_in, p, r, b, rxv, txv, a, bb);
    @(negedge clk);
    check_now();
    drive(r_in, p, r, b, rxv, txv, a, bb);
  endtask

  task automatic rand_step();
    logic p, r;
    p = ($urandom % 4) != 0;
    r = ($urandom % 3) == 0;
    step(1'b0, p, r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    step(1'b1, 0, 0, 0, 0, 0, 0, 0);                                  // R8 reset state
    // Directed: fault with the other inputs all high; spans several phase edges (R1, R9).
    for (int i = 0; i < 3 * T_HALF; i++) step(1'b0, 0, 1, 1, 1, 1, 1, 1);
    // Directed: route override held across phase edges (R2).
    for (int i = 0; i < 3 * T_HALF; i++) step(1'b0, 1, 1, 0, 0, 0, 0, 0);
    // Directed: flash boot, then card boot (R5); UART and user patterns (R3, R4).
    for (int i = 0; i < 4; i++) step(1'b0, 1, 0, 1, i[0], i[1], ~i[0], ~i[1]);
    for (int i = 0; i < 4; i++) step(1'b0, 1, 0, 0, ~i[0], i[1], i[0], ~i[1]);
    // Random mix.
    for (int i = 0; i < 300; i++) rand_step();
    // Reset in the middle of a half period, then check the phase restarts (R8, R6).
    for (int i = 0; i < 2; i++) step(1'b0, 0, 0, 0, 0, 0, 0, 0);
    step(1'b1, 1, 1, 1, 1, 1, 1, 1);
    step(1'b1, 1, 1, 1, 1, 1, 1, 1);
    for (int i = 0; i < 2 * T_HALF + 1; i++) step(1'b0, 0, 0, 1, 0, 1, 0, 1);
    for (int i = 0; i < 300; i++) rand_step();
    @(negedge clk);
    check_now();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule